// File: doc/BRIEF.md
# Register-Mapped Manchester Byte Codec

This peripheral converts a data byte into its 16-bit Manchester form, and back again, inside a small register file on a synchronous register bus. The bus reaches three registers: a control register, a low data register and a high data register. To encode, software writes a byte to the low data register. It then writes the control register with the encode start bit set. One clock later the encoded upper nibble sits in the high data register and the encoded lower nibble has replaced the input in the low data register. At the same moment a sticky ready flag comes up, and it stays up until software clears it.

Decode runs the other way. Software places 16 coded bits in the high and low data registers and sets the decode start bit. The recovered byte lands in the low data register. Any two-bit group that is not a legal Manchester symbol raises a sticky error flag. The mode bit must be zero for either operation to run. The start bits clear themselves, so a single whole-byte write to the control register can launch an operation and clear the old ready flag at the same time.

Top module: `mcodec_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared, and afterwards all four addresses read 0x00.
- R2: Register map. Address 0 is control: bit 0 is the encode start, bit 1 is the decode start, bit 2 is the mode, bit 6 is the error flag and bit 7 is the ready flag; bits 3 to 5 read 0. Address 1 is the low data register and address 2 is the high data register, and both read back what was written. Address 3 reads 0x00 and ignores writes.
- R3: Encode maps each data bit 0 to the pair 10 and each data bit 1 to the pair 01. A nibble's most significant bit goes to the output byte's top pair, so nibble 0x0 gives 0xAA, 0x5 gives 0x99 and 0xF gives 0x55. The upper input nibble goes to the high register and the lower one to the low register.
- R4: The input byte stays readable in the low register up to the start write. Results and ready = 1 are readable after the first clock edge that follows the edge that captured the start write.
- R5: A start bit reads 1 during the single busy cycle after it is written and reads 0 from then on.
- R6: Hardware never clears the ready flag. A control write with bit 7 = 0 clears it; writing bit 7 = 1 never sets it. One write may clear ready and set a start bit together.
- R7: Decode maps the pair 10 to 0 and the pair 01 to 1. The pairs in the high register form the upper nibble and the pairs in the low register form the lower nibble. The byte goes into the low register, and the high register is left unchanged.
- R8: During decode, a pair of 00 or 11 yields data bit 0 and sets the error flag. The flag is sticky: a later valid decode keeps it, and only a control write with bit 6 = 0 clears it.
- R9: With mode = 1, a start bit still clears itself, but the data registers and the ready flag do not change.
- R10: While a start bit is pending (busy), all bus writes are ignored, including writes to the control register.
- R11: If both start bits are written at once, the block performs an encode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |

## Verification
The bench sweeps every byte through encode and every valid 16-bit code word through decode. It also sweeps all 256 high-register patterns through decode, which exercises every invalid pair at every position. The sweeps catch a swapped pair polarity, reversed nibble order or nibble placement, and an error flag that misses one pair position or also fires on valid pairs. Timing probes catch results that arrive a cycle early or late, and a start bit that sticks at 1. Further probes target a ready or error flag that clears by itself or can be set by software, writes that slip through during the busy cycle, a mode bit that fails to block an operation, and decode winning when both start bits are set.

// File: rtl/mcodec_pkg.sv
`timescale 1ns/1ps
// Package: shared address map and control-bit positions for the Manchester codec.
// Assumes an 8-bit control register; bit positions are fixed by the software view.
package mcodec_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_LO   = 2'd1,
        A_HI   = 2'd2,
        A_NONE = 2'd3
    } addr_e;

    localparam int B_ENC  = 0;
    localparam int B_DEC  = 1;
    localparam int B_MODE = 2;
    localparam int B_ERR  = 6;
    localparam int B_RDY  = 7;
endpackage

// File: rtl/mcodec_enc.sv
`timescale 1ns/1ps
// Module: expands one nibble into its Manchester byte, a 0 becoming 10 and a 1 becoming 01.
// Assumes bit i of the nibble owns code bits [2i+1:2i], keeping MSB-first order.
module mcodec_enc #(
    parameter int NIB_W = 4
) (
    input  logic [NIB_W-1:0]   nib,
    output logic [2*NIB_W-1:0] code
);
    // One pair per data bit: upper half is the inverted bit, lower half the bit.
    for (genvar i = 0; i < NIB_W; i++) begin : g_pair
        assign code[2*i+1] = ~nib[i];
        assign code[2*i]   =  nib[i];
    end
endmodule

// File: rtl/mcodec_dec.sv
`timescale 1ns/1ps
// Module: folds a Manchester byte back into a nibble and flags illegal pairs.
// Assumes 10 -> 0, 01 -> 1; 00 and 11 are illegal and decode to 0.
module mcodec_dec #(
    parameter int NIB_W = 4
) (
    input  logic [2*NIB_W-1:0] code,
    output logic [NIB_W-1:0]   nib,
    output logic               bad
);
    logic [NIB_W-1:0] bad_v;

    // Per-pair decode and legality test.
    for (genvar i = 0; i < NIB_W; i++) begin : g_pair
        assign nib[i]   = (code[2*i+1 -: 2] == 2'b01);
        assign bad_v[i] = (code[2*i+1] == code[2*i]);
    end

    assign bad = |bad_v;
endmodule

// File: rtl/mcodec_regs.sv
`timescale 1ns/1ps
// Module: register-mapped Manchester codec. Control at address 0, data low at 1,
// data high at 2. A start bit is held for one busy cycle, during which the
// operation completes and bus writes are ignored.
// Assumes a single-master synchronous bus and BYTE_W >= 8 for the control bits.
module mcodec_regs
    import mcodec_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata
);
    localparam int NIB_W = BYTE_W / 2;

    logic              go_enc, go_dec, mode, err, rdy;
    logic [BYTE_W-1:0] data_lo, data_hi;
    logic [2*BYTE_W-1:0] enc_word;
    logic [2*BYTE_W-1:0] dec_in;
    logic [BYTE_W-1:0] dec_byte;
    logic [1:0]        dec_bad;
    logic              busy, run_enc, run_dec, wr_ok, ctrl_wr;

    assign busy    = go_enc | go_dec;
    assign run_enc = go_enc & ~mode;
    assign run_dec = go_dec & ~go_enc & ~mode;
    assign wr_ok   = bus_wr & ~busy;
    assign ctrl_wr = wr_ok && (bus_addr == A_CTRL);
    assign dec_in  = {data_hi, data_lo};

    // Two nibble lanes: lane 0 is the lower nibble / low register, lane 1 the upper.
    for (genvar h = 0; h < 2; h++) begin : g_lane
        mcodec_enc #(.NIB_W(NIB_W)) u_enc (
            .nib  (data_lo[h*NIB_W +: NIB_W]),
            .code (enc_word[h*BYTE_W +: BYTE_W])
        );
        mcodec_dec #(.NIB_W(NIB_W)) u_dec (
            .code (dec_in[h*BYTE_W +: BYTE_W]),
            .nib  (dec_byte[h*NIB_W +: NIB_W]),
            .bad  (dec_bad[h])
        );
    end

    // Control register: self-clearing starts, sticky ready and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_enc <= 1'b0;
            go_dec <= 1'b0;
            mode   <= 1'b0;
            err    <= 1'b0;
            rdy    <= 1'b0;
        end else if (busy) begin
            go_enc <= 1'b0;
            go_dec <= 1'b0;
            if (run_enc || run_dec) rdy <= 1'b1;
            if (run_dec && (|dec_bad)) err <= 1'b1;
        end else if (ctrl_wr) begin
            go_enc <= bus_wdata[B_ENC];
            go_dec <= bus_wdata[B_DEC];
            mode   <= bus_wdata[B_MODE];
            rdy    <= rdy & bus_wdata[B_RDY];
            err    <= err & bus_wdata[B_ERR];
        end
    end

    // Data registers: operation results take precedence over bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_lo <= '0;
            data_hi <= '0;
        end else if (run_enc) begin
            data_lo <= enc_word[BYTE_W-1:0];
            data_hi <= enc_word[2*BYTE_W-1:BYTE_W];
        end else if (run_dec) begin
            data_lo <= dec_byte;
        end else if (wr_ok) begin
            if (bus_addr == A_LO) data_lo <= bus_wdata;
            if (bus_addr == A_HI) data_hi <= bus_wdata;
        end
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_ENC]  = go_enc;
                bus_rdata[B_DEC]  = go_dec;
                bus_rdata[B_MODE] = mode;
                bus_rdata[B_ERR]  = err;
                bus_rdata[B_RDY]  = rdy;
            end
            A_LO:    bus_rdata = data_lo;
            A_HI:    bus_rdata = data_hi;
            default: bus_rdata = '0;
        endcase
    end

    // Start bits last exactly one cycle.
    p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(go_enc || go_dec));

    // A launched operation with mode 0 raises ready.
    p_ready_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode) |=> rdy);

    // Ready only falls through a control write with bit 7 low.
    p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !(bus_wr && bus_addr == A_CTRL && !bus_wdata[B_RDY])) |=> rdy);

    // Error only falls through a control write with bit 6 low.
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(bus_wr && bus_addr == A_CTRL && !bus_wdata[B_ERR])) |=> err);

    // Mode 1 blocks any change to data and ready.
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode) |=> ($stable(data_lo) && $stable(data_hi) && $stable(rdy)));
endmodule

// File: tb/mcodec_regs_bench.sv
`timescale 1ns/1ps
module mcodec_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mcodec_regs u_mcodec_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] enc_nib(input logic [3:0] n);
        logic [7:0] r = 8'd0;
        for (int i = 0; i < 4; i++) r = r | ((n[i] ? 8'd1 : 8'd2) << (2*i));
        return r;
    endfunction

    function automatic logic [3:0] dec_code(input logic [7:0] c, output bit bad);
        logic [3:0] r = 4'd0;
        bad = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (((c >> (2*i)) & 8'd3) == 8'd1) r[i] = 1'b1;
            else if (((c >> (2*i)) & 8'd3) != 8'd2) bad = 1'b1;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Start an operation, probe the busy cycle, then wait for the completion edge.
    task automatic launch(input logic [7:0] c);
        logic [7:0] v;
        wr(2'd0, c);
        rd(2'd0, v);
        chk("R5 start visible while busy", v & 8'h03, c & ((c & 8'h01) ? 8'h01 : 8'h03));
        @(posedge clk);
    endtask

    initial begin
        #(4*200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit bad;
        logic [7:0] elo;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 reset value", v, 8'h00);
        end

        // R2 register map
        wr(2'd1, 8'h3C); wr(2'd2, 8'hC3); wr(2'd3, 8'hFF);
        rd(2'd1, v); chk("R2 low readback", v, 8'h3C);
        rd(2'd2, v); chk("R2 high readback", v, 8'hC3);
        rd(2'd3, v); chk("R2 unmapped reads zero", v, 8'h00);
        wr(2'd0, 8'h3C);
        rd(2'd0, v); chk("R2 ctrl bits 3-5 read zero", v, 8'h04);
        wr(2'd0, 8'h00);

        // R3/R4 exhaustive encode
        for (int b = 0; b < 256; b++) begin
            wr(2'd1, b[7:0]);
            rd(2'd1, v); chk("R4 input readable before start", v, b[7:0]);
            launch(8'h01);
            rd(2'd1, v); chk("R3 low = encoded lower nibble", v, enc_nib(b[3:0]));
            rd(2'd2, v); chk("R3 high = encoded upper nibble", v, enc_nib(b[7:4]));
            rd(2'd0, v); chk("R4/R5 ready set, start cleared", v, 8'h80);
        end

        // R6 sticky ready
        repeat (5) @(posedge clk);
        rd(2'd0, v); chk("R6 ready holds while idle", v, 8'h80);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R6 ready cleared by write 0", v, 8'h00);
        wr(2'd0, 8'h80);
        rd(2'd0, v); chk("R6 writing 1 does not set ready", v, 8'h00);

        // R7 exhaustive valid decode
        for (int b = 0; b < 256; b++) begin
            wr(2'd1, enc_nib(b[3:0]));
            wr(2'd2, enc_nib(b[7:4]));
            launch(8'h02);
            rd(2'd1, v); chk("R7 decoded byte", v, b[7:0]);
            rd(2'd2, v); chk("R7 high unchanged", v, enc_nib(b[7:4]));
            rd(2'd0, v); chk("R7 ready, no error", v, 8'h80);
        end

        // R8 invalid-pair sweep on the high register
        for (int h = 0; h < 256; h++) begin
            wr(2'd1, 8'hA5);
            wr(2'd2, h[7:0]);
            launch(8'h02);
            elo = {dec_code(h[7:0], bad), 4'h3};
            rd(2'd1, v); chk("R8 decode with invalid pairs", v, elo);
            rd(2'd0, v); chk("R8 error flag", v, bad ? 8'hC0 : 8'h80);
        end
        // R8 invalid pairs in the low register
        wr(2'd1, 8'h3F); wr(2'd2, 8'h99);
        launch(8'h02);
        rd(2'd1, v); chk("R8 low-register invalid pairs", v, 8'h50);
        rd(2'd0, v); chk("R8 error set by low pairs", v, 8'hC0);
        wr(2'd1, 8'hAA); wr(2'd2, 8'hAA);
        launch(8'h42);
        rd(2'd0, v); chk("R8 error survives valid decode", v, 8'hC0);
        wr(2'd0, 8'h80);
        rd(2'd0, v); chk("R8 error cleared by write 0", v, 8'h80);

        // R9 mode 1 blocks operation
        wr(2'd0, 8'h04);
        wr(2'd1, 8'h12); wr(2'd2, 8'h34);
        wr(2'd0, 8'h05);
        @(posedge clk);
        rd(2'd1, v); chk("R9 low untouched", v, 8'h12);
        rd(2'd2, v); chk("R9 high untouched", v, 8'h34);
        rd(2'd0, v); chk("R9 start cleared, no ready", v, 8'h04);
        wr(2'd0, 8'h06);
        @(posedge clk);
        rd(2'd1, v); chk("R9 decode blocked", v, 8'h12);
        rd(2'd0, v); chk("R9 decode start cleared", v, 8'h04);

        // R10 writes ignored while busy
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R10 low write ignored during busy", v, enc_nib(4'hA));
        rd(2'd2, v); chk("R10 high holds result", v, enc_nib(4'h5));
        wr(2'd1, 8'hC3);
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h04);
        rd(2'd0, v); chk("R10 ctrl write ignored during busy", v, 8'h80);

        // R11 both starts: encode wins
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'h03);
        @(posedge clk);
        rd(2'd1, v); chk("R11 encode priority low", v, 8'h55);
        rd(2'd2, v); chk("R11 encode priority high", v, 8'hAA);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule